// File: doc/BRIEF.md
# Configurable Programmable Logic Array

This block is a soft model of a two-level AND/OR logic array whose connections are programmed rather than fixed. It has `N_IN` inputs, `N_TERM` product terms and `N_OUT` outputs, and defaults to a 4 x 6 x 3 array. Every product term can pick, for each input, the true literal, the complemented literal, both or neither. Every output can OR together any subset of the product terms, so a single term can serve several outputs. Each output then passes through a programmable inverter that sets its polarity.

The configuration image is one long shift chain. It is loaded one bit per rising edge of `cfg_clk` while `cfg_en` is high. The bit that leaves the far end of the chain appears on `cfg_out`, so shifting the image round a second time reads it back without loss. Once `cfg_en` is low, `out_vec` depends only on `in_vec` through combinational logic and follows it with no clock delay. Reset returns the chain to the blank state, in which every connection is intact.

Top module: `logic_array_top`

## Requirements
- R1: A synchronous active-high `cfg_rst` sets every image bit to 1 (blank device). With `cfg_en` low, every output then reads 1 and `cfg_out` reads 1.
- R2: While `cfg_en` is high, each rising edge of `cfg_clk` shifts `cfg_in` into the chain. While `cfg_en` is low, the chain holds. The stream runs over L = 2·N_IN·N_TERM + N_TERM·N_OUT + N_OUT bits, and the bit at stream position k (k = 0 is shifted first) has the following meaning:
  - AND plane, at k = t·2·N_IN + 2·i + c: the connection of input i to term t, where c=0 is the true literal and c=1 is the complement.
  - OR plane, at k = 2·N_IN·N_TERM + o·N_TERM + t: the connection of term t to output o.
  - Polarity, at k = 2·N_IN·N_TERM + N_TERM·N_OUT + o: the polarity bit of output o.
- R3: `cfg_out` presents the oldest bit in the chain. After a full load, L further shifts bring out the loaded stream in its load order. Feeding those bits back in leaves the image unchanged.
- R4: While `cfg_en` is high, `out_vec` is all zeros.
- R5: A product term is the AND of its connected literals. A connected true literal of input i requires `in_vec[i]`=1, and a connected complement literal requires `in_vec[i]`=0. An input with neither literal connected does not affect the term.
- R6: A term with both literals of the same input connected is always 0.
- R7: A term with no literals connected is 1.
- R8: Each output is the OR of the terms connected to it, and one term may feed several outputs.
- R9: An output with no terms connected yields 0 before the polarity stage.
- R10: A polarity bit of 0 passes the sum unchanged, and a polarity bit of 1 inverts it.
- R11: With `cfg_en` low, `out_vec` follows `in_vec` combinationally, with no clock edge needed.
- R12: With inputs A=`in_vec[2]`, B=`in_vec[1]`, C=`in_vec[0]`, one image gives `out_vec[0]` = sum of minterms {2,4,5,7} and `out_vec[1]` = sum of minterms {0,1,2,4,6}. The two outputs share the term A·C, and `out_vec[1]` uses inverted polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_rst | input | 1 | Synchronous active-high reset to the blank image |
| cfg_en | input | 1 | Shift enable; also forces outputs low |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out (oldest chain bit) |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Logic outputs |

## Verification
The bench loads two images and drives all sixteen input patterns through each. It compares every result against truth tables built on the bench side. One image packs in the degenerate terms: a term with both literals of an input, a term with no literals, and an output with no terms. A design that treated a contradictory term as a don't-care, or an empty term as 0, would turn a constant output into a live one. A stream laid out in the wrong bit order or direction scrambles the minterm example. That fault also breaks the recirculating readback, and the readback additionally shows whether the chain drifts while the enable is low. Checks on the outputs during a load and just after reset catch a missing output block and a reset to zeros instead of to the blank image.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Total length of the configuration chain
  function automatic int pla_chain_len(input int n_in, input int n_term, input int n_out);
    return 2 * n_in * n_term + n_term * n_out + n_out;
  endfunction

  // Literal selector inside an AND-plane pair
  typedef enum logic {
    LIT_TRUE = 1'b0,
    LIT_COMP = 1'b1
  } lit_sel_e;

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int LEN = 69
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           din,
  output logic [LEN-1:0] image,
  output logic           dout
);

  always_ff @(posedge clk) begin
    if (rst) begin
      image <= '1;
    end else if (en) begin
      image <= {image[LEN-2:0], din};
    end
  end

  assign dout = image[LEN-1];

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_TERM = 6,
  localparam int PAIRS = 2 * N_IN,
  localparam int BITS  = PAIRS * N_TERM
) (
  input  logic [N_IN-1:0]   in_vec,
  input  logic [BITS-1:0]   and_map,
  output logic [N_TERM-1:0] term
);

  logic [PAIRS-1:0] literal;

  genvar gi, gt;
  generate
    for (gi = 0; gi < N_IN; gi++) begin : g_lit
      assign literal[2*gi + int'(LIT_TRUE)] = in_vec[gi];
      assign literal[2*gi + int'(LIT_COMP)] = ~in_vec[gi];
    end

    for (gt = 0; gt < N_TERM; gt++) begin : g_term
      logic [PAIRS-1:0] sel;
      assign sel      = and_map[gt*PAIRS +: PAIRS];
      // unconnected literals read as 1; empty term is 1
      assign term[gt] = &(~sel | literal);
    end
  endgenerate

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 6,
  parameter int N_OUT  = 3,
  localparam int BITS  = N_TERM * N_OUT
) (
  input  logic [N_TERM-1:0] term,
  input  logic [BITS-1:0]   or_map,
  input  logic [N_OUT-1:0]  polarity,
  input  logic              block,
  output logic [N_OUT-1:0]  out_vec
);

  genvar go;
  generate
    for (go = 0; go < N_OUT; go++) begin : g_out
      logic sum;
      assign sum         = |(term & or_map[go*N_TERM +: N_TERM]);
      assign out_vec[go] = block ? 1'b0 : (sum ^ polarity[go]);
    end
  endgenerate

endmodule

// File: rtl/logic_array_top.sv
module logic_array_top
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_TERM = 6,
  parameter int N_OUT  = 3
) (
  input  logic             cfg_clk,
  input  logic             cfg_rst,
  input  logic             cfg_en,
  input  logic             cfg_in,
  output logic             cfg_out,
  input  logic [N_IN-1:0]  in_vec,
  output logic [N_OUT-1:0] out_vec
);

  localparam int AND_BITS = 2 * N_IN * N_TERM;
  localparam int OR_BITS  = N_TERM * N_OUT;
  localparam int LEN      = pla_chain_len(N_IN, N_TERM, N_OUT);

  logic [LEN-1:0]      cfg_image;
  logic [AND_BITS-1:0] and_map;
  logic [OR_BITS-1:0]  or_map;
  logic [N_OUT-1:0]    polarity;
  logic [N_TERM-1:0]   term;

  pla_cfg_chain #(.LEN(LEN)) u_chain (
    .clk  (cfg_clk),
    .rst  (cfg_rst),
    .en   (cfg_en),
    .din  (cfg_in),
    .image(cfg_image),
    .dout (cfg_out)
  );

  // stream position k lives at image bit LEN-1-k
  genvar gk;
  generate
    for (gk = 0; gk < AND_BITS; gk++) begin : g_and_map
      assign and_map[gk] = cfg_image[LEN-1-gk];
    end
    for (gk = 0; gk < OR_BITS; gk++) begin : g_or_map
      assign or_map[gk] = cfg_image[LEN-1-AND_BITS-gk];
    end
    for (gk = 0; gk < N_OUT; gk++) begin : g_pol
      assign polarity[gk] = cfg_image[LEN-1-AND_BITS-OR_BITS-gk];
    end
  endgenerate

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .in_vec (in_vec),
    .and_map(and_map),
    .term   (term)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term    (term),
    .or_map  (or_map),
    .polarity(polarity),
    .block   (cfg_en),
    .out_vec (out_vec)
  );

endmodule

// File: rtl/logic_array_chk.sv
module logic_array_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3,
  parameter int LEN   = 69
) (
  input logic             cfg_clk,
  input logic             cfg_rst,
  input logic             cfg_en,
  input logic             cfg_out,
  input logic [N_IN-1:0]  in_vec,
  input logic [N_OUT-1:0] out_vec,
  input logic [LEN-1:0]   image
);

  assert_blank_R1: assert property (@(posedge cfg_clk) disable iff (cfg_rst)
    $past(cfg_rst) |-> (image == '1 && cfg_out == 1'b1));

  assert_shift_R2: assert property (@(posedge cfg_clk) disable iff (cfg_rst)
    (cfg_en && !$past(cfg_rst)) |=> (cfg_out == $past(image[LEN-2])));

  assert_hold_R2: assert property (@(posedge cfg_clk) disable iff (cfg_rst)
    !cfg_en |=> $stable(image));

  assert_quiet_R4: assert property (@(posedge cfg_clk) disable iff (cfg_rst)
    cfg_en |-> (out_vec == '0));

  assert_comb_R11: assert property (@(posedge cfg_clk) disable iff (cfg_rst)
    (!cfg_en && $past(!cfg_en) && $stable(in_vec) && $stable(image)) |-> $stable(out_vec));

endmodule

bind logic_array_top logic_array_chk #(
  .N_IN (N_IN),
  .N_OUT(N_OUT),
  .LEN  (LEN)
) u_chk (
  .cfg_clk(cfg_clk),
  .cfg_rst(cfg_rst),
  .cfg_en (cfg_en),
  .cfg_out(cfg_out),
  .in_vec (in_vec),
  .out_vec(out_vec),
  .image  (cfg_image)
);

// File: tb/sim_logic_array_top.sv
module sim_logic_array_top;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NT = 6;
  localparam int NO = 3;
  localparam int AB = 2 * NI * NT;
  localparam int OB = NT * NO;
  localparam int L  = AB + OB + NO;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_en = 1'b0;
  logic          cfg_in = 1'b0;
  logic          cfg_out;
  logic [NI-1:0] in_vec = '0;
  logic [NO-1:0] out_vec;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic and_t [NT][NI];
  logic and_c [NT][NI];
  logic or_m  [NO][NT];
  logic pol   [NO];
  logic sbits [L];

  typedef struct {
    logic [NO-1:0] exp;
    string         req;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  logic_array_top #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) u0 (
    .cfg_clk(clk),
    .cfg_rst(rst),
    .cfg_en (cfg_en),
    .cfg_in (cfg_in),
    .cfg_out(cfg_out),
    .in_vec (in_vec),
    .out_vec(out_vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_cfg();
    for (int t = 0; t < NT; t++)
      for (int i = 0; i < NI; i++) begin
        and_t[t][i] = 1'b0;
        and_c[t][i] = 1'b0;
      end
    for (int o = 0; o < NO; o++) begin
      pol[o] = 1'b0;
      for (int t = 0; t < NT; t++) or_m[o][t] = 1'b0;
    end
  endtask

  // stream order per R2
  task automatic build_stream();
    for (int t = 0; t < NT; t++)
      for (int i = 0; i < NI; i++) begin
        sbits[t*2*NI + 2*i]     = and_t[t][i];
        sbits[t*2*NI + 2*i + 1] = and_c[t][i];
      end
    for (int o = 0; o < NO; o++) begin
      for (int t = 0; t < NT; t++) sbits[AB + o*NT + t] = or_m[o][t];
      sbits[AB + OB + o] = pol[o];
    end
  endtask

  function automatic logic [NO-1:0] model(input logic [NI-1:0] x);
    logic [NT-1:0] p;
    logic [NO-1:0] y;
    for (int t = 0; t < NT; t++) begin
      p[t] = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (and_t[t][i] && !x[i]) p[t] = 1'b0;
        if (and_c[t][i] &&  x[i]) p[t] = 1'b0;
      end
    end
    for (int o = 0; o < NO; o++) begin
      y[o] = 1'b0;
      for (int t = 0; t < NT; t++) if (or_m[o][t] && p[t]) y[o] = 1'b1;
      y[o] = y[o] ^ pol[o];
    end
    return y;
  endfunction

  task automatic load_image();
    build_stream();
    @(negedge clk);
    cfg_en = 1'b1;
    in_vec = 4'hF;
    for (int k = 0; k < L; k++) begin
      cfg_in = sbits[k];
      if (k == 5) chk("R4 outputs low while loading", 32'(out_vec), 32'h0);
      @(negedge clk);
    end
    cfg_en = 1'b0;
  endtask

  task automatic readback(input string req);
    @(negedge clk);
    cfg_en = 1'b1;
    for (int k = 0; k < L; k++) begin
      chk(req, 32'(cfg_out), 32'(sbits[k]));
      cfg_in = sbits[k];
      @(negedge clk);
    end
    cfg_en = 1'b0;
  endtask

  // driver: apply a pattern, push the expected result
  task automatic drive(input logic [NI-1:0] x, input logic [NO-1:0] exp, input string req);
    item_t it;
    @(posedge clk);
    #1;
    in_vec = x;
    it.exp = exp;
    it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk(it.req, 32'(out_vec), 32'(it.exp));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] f1_set;
    logic [7:0] f2_set;
    f1_set = 8'hB4;   // minterms 2,4,5,7
    f2_set = 8'h57;   // minterms 0,1,2,4,6

    repeat (3) @(negedge clk);
    rst = 1'b0;
    in_vec = 4'h5;
    @(negedge clk);
    chk("R1 blank outputs", 32'(out_vec), 32'h7);
    chk("R1 blank cfg_out", 32'(cfg_out), 32'h1);

    // image 1: R12 minterm example, A=in[2] B=in[1] C=in[0]
    clear_cfg();
    and_t[0][2] = 1'b1; and_c[0][1] = 1'b1;                      // A B'
    and_t[1][2] = 1'b1; and_t[1][0] = 1'b1;                      // A C (shared, R8)
    and_c[2][2] = 1'b1; and_t[2][1] = 1'b1; and_c[2][0] = 1'b1;  // A' B C'
    and_t[3][1] = 1'b1; and_t[3][0] = 1'b1;                      // B C
    or_m[0][0] = 1'b1; or_m[0][1] = 1'b1; or_m[0][2] = 1'b1;
    or_m[1][1] = 1'b1; or_m[1][3] = 1'b1;
    pol[1] = 1'b1;                                               // R10 invert
    load_image();
    for (int x = 0; x < 16; x++) begin
      logic [2:0] m;
      m = 3'(x);
      // out2 has no terms: R9 -> 0
      drive(4'(x), {1'b0, f2_set[m], f1_set[m]}, "R12 R8 R9 R10 minterm example");
    end
    drain();

    // R11: output follows input with no clock edge
    @(negedge clk);
    #1 in_vec = 4'h2;
    #1 chk("R11 comb follow m2", 32'(out_vec), 32'h3);
    in_vec = 4'h3;
    #1 chk("R11 comb follow m3", 32'(out_vec), 32'h0);

    // R2 hold: clocks with enable low must not disturb the chain
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cfg_in = k[0];
    end
    readback("R3 R2 readback image 1");
    drive(4'h4, 3'b011, "R3 image intact after readback");
    drain();

    // image 2: degenerate terms
    clear_cfg();
    and_t[0][1] = 1'b1; and_c[0][1] = 1'b1; and_t[0][0] = 1'b1;  // R6 contradiction
    or_m[0][0] = 1'b1;
    or_m[1][1] = 1'b1;                                           // R7 empty term
    and_t[2][3] = 1'b1; and_c[2][0] = 1'b1;                      // R5 in3 & ~in0
    or_m[2][2] = 1'b1;
    pol[2] = 1'b1;
    load_image();
    for (int x = 0; x < 16; x++) begin
      logic [NI-1:0] xv;
      logic [NO-1:0] e;
      xv = 4'(x);
      e[0] = 1'b0;
      e[1] = 1'b1;
      e[2] = ~(xv[3] & ~xv[0]);
      drive(xv, e, "R5 R6 R7 degenerate terms");
      chk("R5 bench model agrees", 32'(model(xv)), 32'(e));
    end
    drain();
    readback("R3 readback image 2");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule